// File: doc/BRIEF.md
# Quad Double-Buffered Converter Register Front End

This block is the digital side of a four-channel, 12-bit converter. A host reaches it over a parallel bidirectional data bus, using a 2-bit channel address, an active-low chip select, a read/write strobe, an active-low load strobe and an active-low reset. Each channel keeps two registers. The staging register receives host writes and can be read back. The code register drives that channel's 12-bit straight-binary output code to the converter core.

Data moves from the staging registers to the code registers in one of two ways. In transparent mode, a write made while load is low updates both registers of the addressed channel. In broadcast mode, holding load low while the chip is deselected copies every staging register into its code register at once. A broadcast needs a minimum number of consecutive load-low clock cycles before it takes effect, which models a minimum pulse width on the load pin. Reset forces every register to a code chosen by a parameter: midscale 0x800 or zero 0x000.

All inputs are sampled on the rising clock edge. Readback is combinational within the cycle in which the read is requested.

Top module: `quad_dac_regs`

## Requirements
- R1: The address picks the channel: 00 is channel A, 01 is B, 10 is C and 11 is D. Channel k's 12-bit code appears on `dac_code[12k+11:12k]`, with bit 11 as the MSB and straight-binary coding.
- R2: While `cs_n` is high, no staging register is written, whatever `rw`, `addr` and the bus carry, and the block does not drive the bus.
- R3: A cycle with `cs_n` low and `rw` low stores the bus value into the addressed staging register at that clock edge.
- R4: While `cs_n` is low and `rw` is high, the block drives the addressed staging register onto the bus in the same cycle, and a read changes no register.
- R5: A write made with `load_n` low also stores the value into the addressed code register at the same edge. The code registers of the other channels hold.
- R6: A write made with `load_n` high leaves every code register unchanged.
- R7: With `cs_n` high, every code register copies its staging register at each edge where `load_n` has been low for at least `LOAD_MIN_CYC` consecutive sampled cycles, the current one included. A shorter low pulse has no effect.
- R8: With `cs_n` high and `load_n` high, every register holds its value.
- R9: A low `rst_n` at a clock edge sets all eight registers to the reset code, whatever the other inputs are. The reset code is 0x800 when `MIDSCALE_RST` is 1 and 0x000 when it is 0. A read requested while `rst_n` is low returns the reset code, and writes made then are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low, overrides all operations |
| cs_n | input | 1 | Chip select, active low |
| rw | input | 1 | 1 = read staging register, 0 = write |
| addr | input | 2 | Channel address, A = 00 through D = 11 |
| load_n | input | 1 | Load strobe, active low |
| bus | inout | 12 | Bidirectional data bus |
| dac_code | output | 48 | Four code registers, channel A in bits 11:0 |

## Verification
Two collisions are exercised. Reset is held low in the same cycles as a write and as a read, and the check is that the written value never reaches any register and that the read returns the reset code. A transparent write is also issued in the cycle right after a load-low stretch: the load-low cycles of a selected write count toward the broadcast width, so the bench releases chip select in the following cycle and expects the broadcast to fire only once its own count of consecutive load-low cycles reaches the minimum. All expectations come from a bench model of the eight registers and of the load run length, and a scoreboard compares them with the bus and the four codes.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;

  // Code loaded by reset: half scale or zero for a width-bit binary word.
  function automatic logic [31:0] reset_code(input int unsigned width, input bit midscale);
    return midscale ? (32'd1 << (width - 1)) : 32'd0;
  endfunction

  // Width of a counter that must reach the value lim.
  function automatic int unsigned cnt_width(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

endpackage

// File: rtl/dac_load_qual.sv
module dac_load_qual #(
  parameter int unsigned MIN_CYC = 43
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_n,
  output logic load_ok
);
  import quad_dac_pkg::*;

  localparam int unsigned CW = cnt_width(MIN_CYC);
  localparam logic [CW-1:0] SAT = CW'(MIN_CYC - 1);

  // Number of consecutive earlier cycles with load low, saturating.
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       run_q <= '0;
    else if (load_n)  run_q <= '0;
    else if (run_q != SAT) run_q <= run_q + 1'b1;
  end

  assign load_ok = !load_n && (run_q >= SAT);

  a_r7_run_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    load_n |=> !load_ok || (MIN_CYC == 1));

endmodule

// File: rtl/dac_chan_regs.sv
module dac_chan_regs #(
  parameter int unsigned DATA_W = 12,
  parameter logic [DATA_W-1:0] RST_CODE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              pass_en,
  input  logic              upd_all,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] stage_q,
  output logic [DATA_W-1:0] code_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= RST_CODE;
      code_q  <= RST_CODE;
    end else begin
      if (wr_en) stage_q <= din;
      if (wr_en && pass_en) code_q <= din;
      else if (upd_all)     code_q <= stage_q;
    end
  end

  a_r9_reset_code: assert property (@(posedge clk)
    !rst_n |=> (stage_q == RST_CODE) && (code_q == RST_CODE));

  a_r3_stage_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> stage_q == $past(din));

  a_r5_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && pass_en) |=> code_q == $past(din));

  a_r6_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !pass_en) |=> $stable(code_q));

  a_r7_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
    upd_all |=> code_q == $past(stage_q));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !upd_all) |=> $stable(stage_q) && $stable(code_q));

endmodule

// File: rtl/quad_dac_regs.sv
module quad_dac_regs #(
  parameter int unsigned CHANNELS     = 4,
  parameter int unsigned DATA_W       = 12,
  parameter bit          MIDSCALE_RST = 1'b1,
  parameter int unsigned LOAD_MIN_CYC = 43
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cs_n,
  input  logic                         rw,
  input  logic [$clog2(CHANNELS)-1:0]  addr,
  input  logic                         load_n,
  inout  wire  [DATA_W-1:0]            bus,
  output logic [CHANNELS*DATA_W-1:0]   dac_code
);
  import quad_dac_pkg::*;

  localparam int unsigned ADDR_W = $clog2(CHANNELS);
  localparam logic [DATA_W-1:0] RST_CODE = DATA_W'(reset_code(DATA_W, MIDSCALE_RST));

  // Named events for the assertions.
  logic                 sel_act;   // decode enabled and not in reset
  logic                 wr_any;    // write request accepted this cycle
  logic                 rd_req;    // host asks for readback
  logic                 load_ok;   // load strobe long enough
  logic                 upd_all;   // broadcast copy this cycle
  logic [CHANNELS-1:0]  wr_vec;    // per-channel write strobes
  logic [DATA_W-1:0]    rd_data;
  logic [DATA_W-1:0]    stage_q [CHANNELS];
  logic [DATA_W-1:0]    code_q  [CHANNELS];

  assign sel_act = !cs_n && rst_n;
  assign wr_any  = sel_act && !rw;
  assign rd_req  = !cs_n && rw;
  assign upd_all = cs_n && rst_n && load_ok;

  dac_load_qual #(.MIN_CYC(LOAD_MIN_CYC)) u_load_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_n  (load_n),
    .load_ok (load_ok)
  );

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    assign wr_vec[ch] = wr_any && (addr == ADDR_W'(ch));

    dac_chan_regs #(.DATA_W(DATA_W), .RST_CODE(RST_CODE)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_vec[ch]),
      .pass_en (!load_n),
      .upd_all (upd_all),
      .din     (bus),
      .stage_q (stage_q[ch]),
      .code_q  (code_q[ch])
    );

    assign dac_code[ch*DATA_W +: DATA_W] = code_q[ch];
  end

  assign rd_data = rst_n ? stage_q[addr] : RST_CODE;
  assign bus     = rd_req ? rd_data : 'z;

  a_r1_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |-> $countones(wr_vec) == 1);

  a_r2_no_decode: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> $onehot0(wr_vec) && (wr_vec == '0));

  a_r4_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !upd_all) |=> $stable(dac_code));

  if (LOAD_MIN_CYC >= 2) begin : g_width_chk
    a_r7_min_width: assert property (@(posedge clk) disable iff (!rst_n)
      upd_all |-> !load_n && $past(!load_n));
  end

endmodule

// File: tb/test_quad_dac_regs.sv
module test_quad_dac_regs;
  localparam int MIN = 43;
  localparam logic [11:0] RC = 12'h800;

  logic clk = 1'b0;
  logic rst_n = 1'b0, cs_n = 1'b1, rw = 1'b1, load_n = 1'b1;
  logic [1:0] addr = '0;
  logic [11:0] tb_drv = '0;
  logic tb_en = 1'b0;
  wire  [11:0] bus;
  wire  [11:0] bus_z;
  logic [47:0] dac_code, code_z;

  assign bus = tb_en ? tb_drv : 'z;

  always #2 clk = ~clk;  // 250 MHz

  quad_dac_regs #(.LOAD_MIN_CYC(MIN)) i_quad_dac_regs (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .addr(addr),
    .load_n(load_n), .bus(bus), .dac_code(dac_code));

  // Zero-reset variant, never selected.
  quad_dac_regs #(.MIDSCALE_RST(1'b0), .LOAD_MIN_CYC(MIN)) i_quad_dac_regs_zero (
    .clk(clk), .rst_n(rst_n), .cs_n(1'b1), .rw(1'b1), .addr(2'b00),
    .load_n(1'b1), .bus(bus_z), .dac_code(code_z));

  typedef struct {
    int          due;
    bit          is_bus;
    int          ch;
    logic [11:0] exp;
    string       req;
  } item_t;

  item_t sb_q[$];
  int cyc = 0;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // Reference model.
  logic [11:0] m_stage [4];
  logic [11:0] m_code  [4];
  int m_run = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic judge(input bit ok, input string req, input string what,
                       input logic [11:0] act, input logic [11:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %03h expected %03h", req, what, act, exp);
    end
  endtask

  // Driver: one bus cycle, updates model and pushes expectations.
  task automatic step(input bit r, input bit c, input bit w, input logic [1:0] a,
                      input bit l, input logic [11:0] d, input string req);
    item_t it;
    @(negedge clk);
    rst_n = r; cs_n = c; rw = w; addr = a; load_n = l;
    tb_drv = d; tb_en = !w;
    if (!r) begin
      if (!c && w) begin
        it = '{due: cyc, is_bus: 1'b1, ch: a, exp: RC, req: req};
        sb_q.push_back(it);
      end
      for (int k = 0; k < 4; k++) begin m_stage[k] = RC; m_code[k] = RC; end
      m_run = 0;
    end else begin
      m_run = l ? 0 : m_run + 1;
      if (!c && w) begin
        it = '{due: cyc, is_bus: 1'b1, ch: a, exp: m_stage[a], req: req};
        sb_q.push_back(it);
      end
      if (!c && !w) begin
        m_stage[a] = d;
        if (!l) m_code[a] = d;
      end
      if (c && !l && m_run >= MIN)
        for (int k = 0; k < 4; k++) m_code[k] = m_stage[k];
    end
    for (int k = 0; k < 4; k++) begin
      it = '{due: cyc + 1, is_bus: 1'b0, ch: k, exp: m_code[k], req: req};
      sb_q.push_back(it);
    end
  endtask

  // Monitor: compares items that fall due in this cycle.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
        item_t it;
        it = sb_q.pop_front();
        if (it.is_bus)
          judge(bus == it.exp, it.req, $sformatf("readback ch%0d", it.ch), bus, it.exp);
        else
          judge(dac_code[it.ch*12 +: 12] == it.exp, it.req,
                $sformatf("code ch%0d", it.ch), dac_code[it.ch*12 +: 12], it.exp);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) begin m_stage[k] = 'x; m_code[k] = 'x; end
    // R9: reset state, midscale variant
    step(0, 1, 1, 0, 1, 0, "R9");
    step(0, 1, 1, 0, 1, 0, "R9");
    @(negedge clk); #1;
    for (int k = 0; k < 4; k++)
      judge(code_z[k*12 +: 12] == 12'h000, "R9", "zero variant", code_z[k*12 +: 12], 12'h000);
    // R3, R6, R1: buffered writes to each channel, then readback
    step(1, 0, 0, 2'b00, 1, 12'h123, "R6");
    step(1, 0, 0, 2'b01, 1, 12'h456, "R6");
    step(1, 0, 0, 2'b10, 1, 12'h789, "R6");
    step(1, 0, 0, 2'b11, 1, 12'hABC, "R6");
    for (int k = 0; k < 4; k++) step(1, 0, 1, 2'(k), 1, 0, "R1");
    // R7: a pulse one cycle too short does nothing
    for (int k = 0; k < MIN - 1; k++) step(1, 1, 1, 0, 0, 0, "R7");
    step(1, 1, 1, 0, 1, 0, "R7");
    // R7: full-width pulse copies all, and keeps copying while low
    for (int k = 0; k < MIN + 2; k++) step(1, 1, 1, 0, 0, 0, "R7");
    step(1, 1, 1, 0, 1, 0, "R8");
    // R5: transparent write on channel C only; boundary codes
    step(1, 0, 0, 2'b10, 0, 12'hFFF, "R5");
    step(1, 0, 0, 2'b00, 0, 12'h000, "R5");
    step(1, 0, 1, 2'b10, 1, 0, "R4");
    // R2: deselected write attempt is ignored
    step(1, 1, 0, 2'b01, 1, 12'h5A5, "R2");
    step(1, 0, 1, 2'b01, 1, 0, "R2");
    // R8: idle cycles hold everything
    for (int k = 0; k < 3; k++) step(1, 1, 1, 2'(k), 1, 0, "R8");
    // R4: read with load low changes nothing
    step(1, 0, 1, 2'b11, 0, 0, "R4");
    // R6: buffered write then read, then load-low writes counting toward a broadcast
    step(1, 0, 0, 2'b11, 1, 12'h3C3, "R6");
    for (int k = 0; k < MIN - 2; k++) step(1, 0, 0, 2'b01, 0, 12'(k), "R5");
    step(1, 1, 1, 0, 0, 0, "R7");
    step(1, 1, 1, 0, 0, 0, "R7");
    step(1, 1, 1, 0, 1, 0, "R7");
    step(1, 0, 0, 2'b11, 1, 12'h777, "R3");
    step(1, 0, 1, 2'b11, 1, 0, "R3");
    // R9: reset together with a write, then with a read
    step(0, 0, 0, 2'b01, 0, 12'h999, "R9");
    step(0, 0, 1, 2'b01, 1, 0, "R9");
    for (int k = 0; k < 4; k++) step(1, 0, 1, 2'(k), 1, 0, "R9");
    step(1, 1, 1, 0, 1, 0, "R8");
    repeat (3) @(negedge clk);
    #2;
    judge(sb_q.size() == 0, "R8", "scoreboard drained", 12'(sb_q.size()), 12'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule